// File: doc/BRIEF.md
# LCD Row-Scan Timing Generator

This block produces the row-side scan timing for a dot-matrix LCD. It runs from a system clock qualified by an oscillator tick. From that tick it builds a line shift clock (CL2), a one-line frame marker (FRM), an AC-inversion level (M) and a pair of non-overlapping column clocks (CLK1/CLK2). It also runs a row shift register that walks a single active bit across the panel rows once per frame. The analog parts of a real row driver are not modelled: there is no oscillator, no high-voltage output stage and no bias generation. Each row output is a plain logic bit.

In master mode the block generates all of its timing itself. In slave mode it follows CL2 and M from another device and takes row data in through one of its two serial pins. The other pin passes the data on to the next device in the chain. Four duty settings set the number of lines per frame. A phase select picks the CL2 edge on which rows shift. A frequency select halves the tick rate, so that a fast oscillator and a slow one give the same frame rate. Each bidirectional serial pin is split into an input, an output and an output enable.

Top module: `lcd_row_timing`

## Requirements
- R1: While reset is held and just after it is released, row_o is all zero and m_o, frm_o and cl2_o are 0 in master mode.
- R2: In master mode the CL2 period is 2*HALF_DIV base ticks. A base tick is every osc_tick_i when freq_sel_i=0 and every second osc_tick_i when freq_sel_i=1, so freq_sel_i=1 doubles the period (4 and 8 clocks by default with a tick on every clock).
- R3: In master mode FRM pulses are spaced N CL2 periods apart, where duty_sel_i = 00 gives N=48, 01 gives N=64, 10 gives N=96 and 11 gives N=128.
- R4: In master mode FRM stays high for exactly one CL2 period per frame. It rises one clock after the CL2 rising edge that ends the last line.
- R5: In master mode M toggles exactly when FRM rises and holds its level at every other time.
- R6: In master mode CLK1 and CLK2 each have a period of 8 base ticks. Each is low for 2 ticks and high for 6. CLK2 is low 4 ticks after CLK1, so the two are never low together. In slave mode both are held high.
- R7: With phase_sel_i=1 the rows shift on the rising edge of CL2. With phase_sel_i=0 they shift on the falling edge. The new row value appears one clock after the edge reaches cl2_o.
- R8: In master mode both dio output enables are 1. A 1 is shifted in during the FRM line: at row_o[0] when shl_i=1, or at row_o[ROWS-1] when shl_i=0. The entry-side pin (dio1 when shl_i=1, dio2 when shl_i=0) drives the FRM level, and the far pin drives the last row stage.
- R9: In slave mode with shl_i=1, dio1 is an input (dio1_oe_o=0) whose value enters row_o[0] and moves toward higher rows. dio2_oe_o=1 and dio2_o equals row_o[ROWS-1].
- R10: In slave mode with shl_i=0, dio2 is an input (dio2_oe_o=0) whose value enters row_o[ROWS-1] and moves toward lower rows. dio1_oe_o=1 and dio1_o equals row_o[0].
- R11: In slave mode cl2_o follows ext_cl2_i, m_o follows ext_m_i, and frm_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | Oscillator tick, one clock wide |
| master_i | input | 1 | 1 = generate timing, 0 = follow external CL2/M |
| freq_sel_i | input | 1 | 1 = fast oscillator, ticks divided by two |
| duty_sel_i | input | 2 | Lines per frame: 48/64/96/128 |
| phase_sel_i | input | 1 | 1 = shift on CL2 rise, 0 = on fall |
| shl_i | input | 1 | Shift direction, 1 = toward higher rows |
| ext_cl2_i | input | 1 | External line clock (slave) |
| ext_m_i | input | 1 | External AC-inversion level (slave) |
| dio1_i | input | 1 | Serial pin 1, input side |
| dio1_o | output | 1 | Serial pin 1, output side |
| dio1_oe_o | output | 1 | Serial pin 1 output enable |
| dio2_i | input | 1 | Serial pin 2, input side |
| dio2_o | output | 1 | Serial pin 2, output side |
| dio2_oe_o | output | 1 | Serial pin 2 output enable |
| cl2_o | output | 1 | Line shift clock |
| frm_o | output | 1 | Frame marker |
| m_o | output | 1 | AC-inversion level |
| clk1_o | output | 1 | Column clock phase 1 |
| clk2_o | output | 1 | Column clock phase 2 |
| row_o | output | ROWS | Row select bits, bit 0 = row 1 |

## Verification
A row shift shows on row_o one clock after the matching CL2 level change appears on cl2_o. The bench drives slave CL2 on a falling clock edge and reads the rows two falling edges later, once after each half of the pulse. This separates a rising-edge shift from a falling-edge shift. In master mode FRM and M change one clock after the internal CL2 rise, and the shift injected on the falling edge lands two clocks after FRM is first seen high, so those checks count falling edges from the FRM rise. Pin directions, pin values and the slave pass-through paths are combinational and are read on the falling edge after the inputs change.

// File: rtl/lcd_row_pkg.sv
package lcd_row_pkg;
  localparam int unsigned LINE_W = 8;

  typedef enum logic [1:0] {
    DUTY_48  = 2'b00,
    DUTY_64  = 2'b01,
    DUTY_96  = 2'b10,
    DUTY_128 = 2'b11
  } duty_e;

  function automatic logic [LINE_W-1:0] duty_lines(input duty_e sel);
    case (sel)
      DUTY_48:  duty_lines = LINE_W'(48);
      DUTY_64:  duty_lines = LINE_W'(64);
      DUTY_96:  duty_lines = LINE_W'(96);
      default:  duty_lines = LINE_W'(128);
    endcase
  endfunction
endpackage

// File: rtl/lcd_row_clkgen.sv
module lcd_row_clkgen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic osc_tick_i,
  input  logic freq_sel_i,
  output logic cl2_o,
  output logic clk1_o,
  output logic clk2_o
);
  localparam int unsigned HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HALF_DIV - 1);

  logic          pre_q;
  logic          base_tick;
  logic [HW-1:0] hcnt_q;
  logic          cl2_q;
  logic [2:0]    ph_q;

  // fast oscillator: keep every second tick
  assign base_tick = en_i & osc_tick_i & (~freq_sel_i | pre_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= 1'b0;
    end else if (!en_i || !freq_sel_i) begin
      pre_q <= 1'b0;
    end else if (osc_tick_i) begin
      pre_q <= ~pre_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      cl2_q  <= 1'b0;
    end else if (base_tick) begin
      if (hcnt_q == HLAST) begin
        hcnt_q <= '0;
        cl2_q  <= ~cl2_q;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
    end else if (base_tick) begin
      ph_q <= ph_q + 3'd1;
    end
  end

  // 8-step ring: phase 1 low in steps 0-1, phase 2 low in steps 4-5
  assign cl2_o  = cl2_q;
  assign clk1_o = en_i ? (ph_q > 3'd1) : 1'b1;
  assign clk2_o = en_i ? !((ph_q == 3'd4) || (ph_q == 3'd5)) : 1'b1;
endmodule

// File: rtl/lcd_row_frame.sv
module lcd_row_frame
  import lcd_row_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rise_i,
  input  logic [1:0] duty_sel_i,
  output logic       wrap_o,
  output logic       frm_o,
  output logic       m_o
);
  logic [LINE_W-1:0] lcnt_q;
  logic [LINE_W-1:0] last_line;
  logic              frm_q;
  logic              m_q;

  assign last_line = duty_lines(duty_e'(duty_sel_i)) - 1'b1;
  // ">=" so a shorter duty chosen mid-frame still wraps
  assign wrap_o    = en_i & rise_i & (lcnt_q >= last_line);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcnt_q <= '0;
      frm_q  <= 1'b0;
      m_q    <= 1'b0;
    end else if (!en_i) begin
      lcnt_q <= '0;
      frm_q  <= 1'b0;
    end else if (rise_i) begin
      if (wrap_o) begin
        lcnt_q <= '0;
        frm_q  <= 1'b1;
        m_q    <= ~m_q;
      end else begin
        lcnt_q <= lcnt_q + 1'b1;
        frm_q  <= 1'b0;
      end
    end
  end

  assign frm_o = frm_q;
  assign m_o   = m_q;
endmodule

// File: rtl/lcd_row_shifter.sv
module lcd_row_shifter #(
  parameter int unsigned ROWS = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            up_i,
  input  logic            din_i,
  output logic [ROWS-1:0] rows_o
);
  logic [ROWS-1:0] q;
  logic [ROWS-1:0] nxt;

  for (genvar i = 0; i < ROWS; i++) begin : g_stage
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_first
      assign from_low = din_i;
    end else begin : g_mid_lo
      assign from_low = q[i-1];
    end
    if (i == ROWS - 1) begin : g_last
      assign from_high = din_i;
    end else begin : g_mid_hi
      assign from_high = q[i+1];
    end
    assign nxt[i] = up_i ? from_low : from_high;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (shift_i) begin
      q <= nxt;
    end
  end

  assign rows_o = q;
endmodule

// File: rtl/lcd_row_timing.sv
module lcd_row_timing #(
  parameter int unsigned ROWS     = 64,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            osc_tick_i,
  input  logic            master_i,
  input  logic            freq_sel_i,
  input  logic [1:0]      duty_sel_i,
  input  logic            phase_sel_i,
  input  logic            shl_i,
  input  logic            ext_cl2_i,
  input  logic            ext_m_i,
  input  logic            dio1_i,
  output logic            dio1_o,
  output logic            dio1_oe_o,
  input  logic            dio2_i,
  output logic            dio2_o,
  output logic            dio2_oe_o,
  output logic            cl2_o,
  output logic            frm_o,
  output logic            m_o,
  output logic            clk1_o,
  output logic            clk2_o,
  output logic [ROWS-1:0] row_o
);
  logic cl2_int;
  logic cl2_eff;
  logic cl2_q;
  logic rise_evt;
  logic fall_evt;
  logic shift_en;
  logic wrap;
  logic frm_int;
  logic m_int;
  logic inject;
  logic shift_in;
  logic [ROWS-1:0] rows;

  lcd_row_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (master_i),
    .osc_tick_i (osc_tick_i),
    .freq_sel_i (freq_sel_i),
    .cl2_o      (cl2_int),
    .clk1_o     (clk1_o),
    .clk2_o     (clk2_o)
  );

  assign cl2_eff = master_i ? cl2_int : ext_cl2_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cl2_q <= 1'b0;
    else         cl2_q <= cl2_eff;
  end

  assign rise_evt = cl2_eff & ~cl2_q;
  assign fall_evt = ~cl2_eff & cl2_q;
  assign shift_en = phase_sel_i ? rise_evt : fall_evt;

  lcd_row_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (master_i),
    .rise_i     (rise_evt),
    .duty_sel_i (duty_sel_i),
    .wrap_o     (wrap),
    .frm_o      (frm_int),
    .m_o        (m_int)
  );

  // rising-edge shift coincides with the frame wrap; falling-edge shift sees FRM already set
  assign inject   = phase_sel_i ? wrap : frm_int;
  assign shift_in = master_i ? inject : (shl_i ? dio1_i : dio2_i);

  lcd_row_shifter #(.ROWS(ROWS)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_en),
    .up_i    (shl_i),
    .din_i   (shift_in),
    .rows_o  (rows)
  );

  assign row_o     = rows;
  assign cl2_o     = cl2_eff;
  assign frm_o     = frm_int;
  assign m_o       = master_i ? m_int : ext_m_i;
  assign dio1_oe_o = master_i | ~shl_i;
  assign dio2_oe_o = master_i | shl_i;
  assign dio1_o    = shl_i ? frm_int : rows[0];
  assign dio2_o    = shl_i ? rows[ROWS-1] : frm_int;
endmodule

// File: rtl/lcd_row_checker.sv
module lcd_row_checker #(
  parameter int unsigned ROWS = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            master_i,
  input logic            shl_i,
  input logic            cl2_o,
  input logic            frm_o,
  input logic            m_o,
  input logic            clk1_o,
  input logic            clk2_o,
  input logic            dio1_o,
  input logic            dio1_oe_o,
  input logic            dio2_o,
  input logic            dio2_oe_o,
  input logic [ROWS-1:0] row_o
);
  p_clk_nonoverlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk1_o || clk2_o);

  p_m_on_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && $past(master_i) && $past(rst_ni) && !$stable(m_o) |-> $rose(frm_o));

  p_frm_min_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && $past(master_i) && $past(rst_ni) && $rose(frm_o) |=> frm_o || !master_i);

  p_shift_on_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(rst_ni, 2) && (master_i == $past(master_i)) &&
    ($past(master_i) == $past(master_i, 2)) && !$stable(row_o)
    |-> $past(cl2_o) != $past(cl2_o, 2));

  p_slave_up_pins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i && shl_i |-> !dio1_oe_o && dio2_oe_o && (dio2_o == row_o[ROWS-1]));

  p_slave_down_pins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i && !shl_i |-> dio1_oe_o && !dio2_oe_o && (dio1_o == row_o[0]));

  p_slave_no_frm_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !frm_o);
endmodule

bind lcd_row_timing lcd_row_checker #(.ROWS(ROWS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .master_i  (master_i),
  .shl_i     (shl_i),
  .cl2_o     (cl2_o),
  .frm_o     (frm_o),
  .m_o       (m_o),
  .clk1_o    (clk1_o),
  .clk2_o    (clk2_o),
  .dio1_o    (dio1_o),
  .dio1_oe_o (dio1_oe_o),
  .dio2_o    (dio2_o),
  .dio2_oe_o (dio2_oe_o),
  .row_o     (row_o)
);

// File: tb/lcd_row_timing_bench.sv
module lcd_row_timing_bench;
  localparam int ROWS = 64;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic osc_tick_i = 1'b0;
  logic master_i = 1'b1;
  logic freq_sel_i = 1'b0;
  logic [1:0] duty_sel_i = 2'b00;
  logic phase_sel_i = 1'b1;
  logic shl_i = 1'b1;
  logic ext_cl2_i = 1'b0;
  logic ext_m_i = 1'b0;
  logic dio1_i = 1'b0;
  logic dio2_i = 1'b0;
  logic dio1_o, dio1_oe_o, dio2_o, dio2_oe_o;
  logic cl2_o, frm_o, m_o, clk1_o, clk2_o;
  logic [ROWS-1:0] row_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk_i = ~clk_i;

  lcd_row_timing u_lcd_row_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_tick_i(osc_tick_i), .master_i(master_i),
    .freq_sel_i(freq_sel_i), .duty_sel_i(duty_sel_i), .phase_sel_i(phase_sel_i),
    .shl_i(shl_i), .ext_cl2_i(ext_cl2_i), .ext_m_i(ext_m_i),
    .dio1_i(dio1_i), .dio1_o(dio1_o), .dio1_oe_o(dio1_oe_o),
    .dio2_i(dio2_i), .dio2_o(dio2_o), .dio2_oe_o(dio2_oe_o),
    .cl2_o(cl2_o), .frm_o(frm_o), .m_o(m_o), .clk1_o(clk1_o), .clk2_o(clk2_o),
    .row_o(row_o)
  );

  // slave vectors {shl, phase, din}
  localparam logic [2:0] VEC [12] = '{
    3'b111, 3'b101, 3'b110, 3'b111, 3'b100, 3'b011,
    3'b001, 3'b010, 3'b011, 3'b111, 3'b001, 3'b110
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  function automatic int lines_for(input logic [1:0] d);
    case (d)
      2'b00: return 48;
      2'b01: return 64;
      2'b10: return 96;
      default: return 128;
    endcase
  endfunction

  task automatic wait_frm_rise();
    logic prev;
    prev = frm_o;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if (frm_o && !prev) return;
      prev = frm_o;
    end
  endtask

  task automatic cl2_period(output int per);
    logic prev;
    per = 0;
    prev = cl2_o;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (cl2_o && !prev) break;
      prev = cl2_o;
    end
    prev = cl2_o;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      per++;
      if (cl2_o && !prev) break;
      prev = cl2_o;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int per, span, frm_hi, m_chg;
    logic m_start, m_prev;
    logic [ROWS-1:0] mdl, nxt;

    // R1 reset state, no oscillator ticks
    repeat (2) @(negedge clk_i);
    chk("R1 row in reset", row_o, '0);
    chk("R1 frm in reset", {63'b0, frm_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 row after reset", row_o, '0);
    chk("R1 m/cl2 after reset", {62'b0, m_o, cl2_o}, 64'd0);

    // R8 rising-edge injection, up direction
    osc_tick_i = 1'b1;
    wait_frm_rise();
    chk("R8 inject row1", row_o, 64'h1);
    chk("R8 oe both", {62'b0, dio1_oe_o, dio2_oe_o}, 64'd3);
    chk("R8 entry pin frm", {63'b0, dio1_o}, 64'd1);
    repeat (4) @(negedge clk_i);
    chk("R7 rise shift next line", row_o, 64'h2);
    chk("R4 frm one line", {63'b0, frm_o}, 64'd0);

    // R3/R4/R5 for every duty
    for (int d = 0; d < 4; d++) begin
      duty_sel_i = 2'(d);
      do_reset();
      wait_frm_rise();
      m_start = m_o;
      m_prev = m_o;
      span = 0; frm_hi = 1; m_chg = 0;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk_i);
        span++;
        if (m_o != m_prev) m_chg++;
        m_prev = m_o;
        if (frm_o && span > 8) break;
        if (frm_o) frm_hi++;
      end
      chk("R3 frame length", 64'(span), 64'(4 * lines_for(2'(d))));
      chk("R4 frm width", 64'(frm_hi), 64'd4);
      chk("R5 m toggles once", 64'(m_chg), 64'd1);
      chk("R5 m flipped", {63'b0, m_o}, {63'b0, ~m_start});
    end

    // R8/R7 falling-edge injection, down direction
    duty_sel_i = 2'b00; phase_sel_i = 1'b0; shl_i = 1'b0;
    do_reset();
    wait_frm_rise();
    chk("R7 no shift before fall", row_o, '0);
    repeat (2) @(negedge clk_i);
    chk("R8 inject row64", row_o, 64'h8000_0000_0000_0000);
    chk("R8 entry pin dio2", {62'b0, dio2_o, dio1_o}, 64'd2);

    // R2 CL2 period at both rates, R6 column clocks
    phase_sel_i = 1'b1; shl_i = 1'b1; freq_sel_i = 1'b0;
    do_reset();
    cl2_period(per);
    chk("R2 cl2 period slow osc", 64'(per), 64'd4);
    begin
      int lo1, lo2, both, f1;
      logic p1;
      lo1 = 0; lo2 = 0; both = 0; f1 = 0; p1 = clk1_o;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk_i);
        if (!clk1_o) lo1++;
        if (!clk2_o) lo2++;
        if (!clk1_o && !clk2_o) both++;
        if (!clk1_o && p1) f1++;
        p1 = clk1_o;
      end
      chk("R6 clk1 low time", 64'(lo1), 64'd16);
      chk("R6 clk2 low time", 64'(lo2), 64'd16);
      chk("R6 no overlap", 64'(both), 64'd0);
      chk("R6 clk1 period", 64'(f1), 64'd8);
    end
    freq_sel_i = 1'b1;
    do_reset();
    cl2_period(per);
    chk("R2 cl2 period fast osc", 64'(per), 64'd8);

    // slave table: R7, R9, R10, R11
    freq_sel_i = 1'b0; master_i = 1'b0; ext_cl2_i = 1'b0;
    do_reset();
    mdl = '0;
    for (int v = 0; v < 12; v++) begin
      shl_i = VEC[v][2];
      phase_sel_i = VEC[v][1];
      if (VEC[v][2]) begin dio1_i = VEC[v][0]; dio2_i = ~VEC[v][0]; end
      else           begin dio2_i = VEC[v][0]; dio1_i = ~VEC[v][0]; end
      nxt = VEC[v][2] ? {mdl[ROWS-2:0], VEC[v][0]} : {VEC[v][0], mdl[ROWS-1:1]};
      @(negedge clk_i);
      if (VEC[v][2]) begin
        chk("R9 pins up", {61'b0, dio1_oe_o, dio2_oe_o, dio2_o}, {61'b0, 2'b01, mdl[ROWS-1]});
      end else begin
        chk("R10 pins down", {61'b0, dio1_oe_o, dio2_oe_o, dio1_o}, {61'b0, 2'b10, mdl[0]});
      end
      ext_cl2_i = 1'b1;
      repeat (2) @(negedge clk_i);
      chk("R11 cl2 follows", {63'b0, cl2_o}, 64'd1);
      chk(VEC[v][2] ? "R7 R9 after rise" : "R7 R10 after rise", row_o, VEC[v][1] ? nxt : mdl);
      ext_cl2_i = 1'b0;
      repeat (2) @(negedge clk_i);
      chk(VEC[v][2] ? "R7 R9 after fall" : "R7 R10 after fall", row_o, nxt);
      mdl = nxt;
    end

    // R11 M pass-through, FRM low; R6 clocks held high
    ext_m_i = 1'b1;
    @(negedge clk_i);
    chk("R11 m follows", {61'b0, m_o, frm_o, cl2_o}, 64'd4);
    chk("R6 slave clks high", {62'b0, clk1_o, clk2_o}, 64'd3);
    ext_m_i = 1'b0;
    @(negedge clk_i);
    chk("R11 m follows low", {63'b0, m_o}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule